// File: doc/BRIEF.md
# Pipelined Burst Cache SRAM Controller

This block is the synchronous control section of a pipelined burst cache SRAM, built around a small internal array. The array has 256 words. Each word holds four byte lanes of nine bits: eight data bits and one parity bit. Every control input is taken on the rising clock edge. A cycle begins on one of two competing strobes: a processor strobe, which always starts a read, or a controller strobe, which samples the write enables on the same edge. Chip-select decode can turn either strobe into a deselect.

Once a burst has started, an on-chip two-bit counter produces the following addresses in linear or XOR-interleaved order. An advance input steps the counter or holds it as a wait state. Writes can cover every lane or only chosen lanes. Read data passes through two registers before it reaches the output, which is qualified by an enable. A sleep input freezes the block and holds its state. When sleep is released, strobes are refused for two further edges while the block wakes.

Top module: `psram_ctl`

## Requirements
- R1: After reset the output enable is low and every array word reads as zero.
- R2: An edge with the processor strobe low, `sel1_n` low, `sel2` high and `sel3_n` low starts a read burst at `addr_in`. The write inputs and the controller strobe have no effect on that edge. While `sel1_n` is high the processor strobe is ignored.
- R3: The controller strobe starts a burst only on an edge where the processor strobe does not start one. On that same edge the write inputs choose between a read and a write at `addr_in`.
- R4: Write decode works as follows:
  - With `all_wr_n` low, all four lanes are written.
  - Otherwise, with `lane_wr_n` low, each lane i whose `lane_en_n[i]` is low is written. Lane i is bits [9i+8:9i].
  - Any other combination is a read.
- R5: With `interleave` low, the burst low address bits after base b are b+1, b+2, b+3 modulo 4, and then b again.
- R6: With `interleave` high, the burst low address bits after base b are b^1, b^2, b^3, and then b again.
- R7: On an edge inside a burst where neither strobe starts a cycle, `adv_n` low moves to the next burst address and `adv_n` high repeats the current one. Either kind of edge may read or write according to R4.
- R8: The word read on edge k appears on `rdata` after edge k+1. From then on `rdata_oe` follows `oe_n` with no clock involved.
- R9: `rdata_oe` is low in the cycle after an edge that writes, in every cycle where `oe_n` is high, and after an edge that made no read.
- R10: A strobe edge that fails the chip-select decode ends any burst and performs no access. Later edges with both strobes high do nothing until a new start.
- R11: An edge with `sleep_req` high performs no access and no write, and clears the output enable. The burst position is kept, so the burst can resume after wake-up.
- R12: The first two edges after `sleep_req` falls ignore both strobes. A strobe on the third edge is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | 8 | External word address |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write-all-lanes enable, active low |
| lane_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| interleave | input | 1 | Burst order: 0 linear, 1 XOR-interleaved; static |
| sleep_req | input | 1 | Sleep request, active high |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Read data from the output register |
| rdata_oe | output | 1 | Drive enable for `rdata` |

## Verification
Two events can land on the same edge. One is a write that clears the output enable. The other is the hand-off of an earlier read into the output register. The bench provokes this by following a read start directly with a write continuation, and expects the pending read word to be dropped instead of shown. The same holds when a sleep edge cuts into a running burst: the bench raises sleep in the middle of a burst and then advances after wake-up. In each case a bench-side model of the array and burst state gives the expected enable and data for every cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;

    // Low two address bits for burst offset off from base, linear or XOR order.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] off,
                                            input logic       ilv);
        return ilv ? (base ^ off) : (base + off);
    endfunction

endpackage

// File: rtl/psram_lane_decode.sv
module psram_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic [LANES-1:0] mask_o,
    output logic             wr_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask_o[i] = !all_wr_n || (!lane_wr_n && !lane_en_n[i]);
    end

    assign wr_o = |mask_o;
endmodule

// File: rtl/psram_pwr.sv
module psram_pwr #(
    parameter int SLEEP_CYC = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic block_o,
    output logic asleep_o
);
    localparam int SW = $clog2(SLEEP_CYC + 1);
    localparam int WW = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic [SW-1:0] slp;
        logic [WW-1:0] wake;
    } pwr_t;

    pwr_t pw_d, pw_q;

    always_comb begin
        pw_d = pw_q;
        if (sleep_req) begin
            pw_d.wake = '0;
            if (pw_q.slp != SW'(SLEEP_CYC)) pw_d.slp = pw_q.slp + 1'b1;
        end else if (pw_q.slp != '0) begin
            pw_d.slp  = '0;
            pw_d.wake = WW'(WAKE_CYC - 1);
        end else if (pw_q.wake != '0) begin
            pw_d.wake = pw_q.wake - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= '0;
        else        pw_q <= pw_d;
    end

    assign block_o  = !sleep_req && ((pw_q.slp != '0) || (pw_q.wake != '0));
    assign asleep_o = (pw_q.slp == SW'(SLEEP_CYC));

    // R12: leaving sleep always arms the wake-up guard for the following edge
    a_r12_wake_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && pw_q.slp != '0) |=> (pw_q.wake != '0 || WAKE_CYC < 2));

    // R11: the sleep counter never passes its limit
    a_r11_sleep_sat: assert property (@(posedge clk) disable iff (!rst_n)
        pw_q.slp <= SW'(SLEEP_CYC));
endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        we_mask,
    input  logic                    rd_en,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;
    localparam int W     = LANES * LANE_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we_mask[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
            if (rd_en) rd_q <= mem[addr];
        end
    end

    // R9: a read and a write never share an edge
    a_r9_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (we_mask == '0));
endmodule

// File: rtl/psram_ctl.sv
module psram_ctl #(
    parameter int AW        = 8,
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter int SLEEP_CYC = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr_in,
    input  logic                    cpu_stb_n,
    input  logic                    ctl_stb_n,
    input  logic                    adv_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    oe_n,
    input  logic                    interleave,
    input  logic                    sleep_req,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    import psram_pkg::*;

    localparam int W = LANES * LANE_W;

    typedef struct packed {
        logic          active;
        logic [AW-1:0] base;
        logic [1:0]    off;
        logic          rd_vld;
        logic          out_vld;
        logic [W-1:0]  out_data;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             pw_block, pw_asleep, hold;
    logic [LANES-1:0] lane_mask;
    logic             lane_wr;
    logic             selected, cpu_go, ctl_go, strobe;
    logic             start_ok, start_bad, cont;
    logic [1:0]       next_off;
    logic [AW-1:0]    acc_addr;
    logic             acc_en, acc_wr, rd_en;
    logic [LANES-1:0] we_mask;
    logic [W-1:0]     arr_rd;

    psram_pwr #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .block_o(pw_block), .asleep_o(pw_asleep)
    );

    psram_lane_decode #(.LANES(LANES)) u_dec (
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n),
        .mask_o(lane_mask), .wr_o(lane_wr)
    );

    psram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .addr(acc_addr), .we_mask(we_mask),
        .rd_en(rd_en), .wdata(wdata), .rd_q(arr_rd)
    );

    always_comb begin
        hold      = sleep_req;
        selected  = !sel1_n && sel2 && !sel3_n;
        cpu_go    = !pw_block && !hold && !cpu_stb_n && !sel1_n;
        ctl_go    = !pw_block && !hold && !ctl_stb_n && !cpu_go;
        strobe    = cpu_go || ctl_go;
        start_ok  = strobe && selected;
        start_bad = strobe && !selected;
        cont      = !hold && !strobe && st_q.active;
        next_off  = adv_n ? st_q.off : st_q.off + 2'd1;

        acc_addr = start_ok ? addr_in
                 : {st_q.base[AW-1:2], burst_lo(st_q.base[1:0], next_off, interleave)};
        acc_en   = start_ok || cont;
        acc_wr   = acc_en && lane_wr && (cont || ctl_go);
        we_mask  = acc_wr ? lane_mask : '0;
        rd_en    = acc_en && !acc_wr;

        st_d = st_q;
        if (hold) begin
            st_d.rd_vld  = 1'b0;
            st_d.out_vld = 1'b0;
        end else begin
            if (start_ok) begin
                st_d.active = 1'b1;
                st_d.base   = addr_in;
                st_d.off    = 2'd0;
            end else if (start_bad) begin
                st_d.active = 1'b0;
            end else if (cont) begin
                st_d.off = next_off;
            end
            st_d.out_vld  = acc_wr ? 1'b0 : st_q.rd_vld;
            st_d.out_data = arr_rd;
            st_d.rd_vld   = rd_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.out_data;
    assign rdata_oe = st_q.out_vld && !oe_n && !pw_asleep;

    // R9: a write edge leaves the output disabled in the next cycle
    a_r9_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !rdata_oe);

    // R2: a selected start resets the burst position
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (st_q.active && st_q.off == 2'd0));

    // R10: a deselecting strobe ends the burst
    a_r10_desel: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> !st_q.active);

    // R7: advance steps the offset by one
    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !adv_n) |=> (st_q.off == $past(st_q.off) + 2'd1));

    // R7: suspend holds the offset
    a_r7_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && adv_n) |=> $stable(st_q.off));

    // R11: sleep edges keep the burst state
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(st_q.active) && $stable(st_q.off) && $stable(st_q.base)));
endmodule

// File: tb/psram_ctl_bench.sv
module psram_ctl_bench;
    localparam int AW = 8;
    localparam int W  = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          cpu_stb_n, ctl_stb_n, adv_n, sel1_n, sel2, sel3_n;
    logic          all_wr_n, lane_wr_n, oe_n, interleave, sleep_req;
    logic [3:0]    lane_en_n;
    logic [W-1:0]  wdata, rdata;
    logic          rdata_oe;

    always #5 clk = ~clk;

    psram_ctl u_psram_ctl (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .cpu_stb_n(cpu_stb_n),
        .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_en_n(lane_en_n), .oe_n(oe_n), .interleave(interleave),
        .sleep_req(sleep_req), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [W-1:0]  m_mem [256];
    logic          m_act, m_rdv, m_outv;
    logic [AW-1:0] m_base;
    logic [1:0]    m_off;
    logic [W-1:0]  m_rdd, m_outd;
    int            m_slp, m_wake;

    function automatic logic [1:0] seq_lo(logic [1:0] b, logic [1:0] k, logic ilv);
        return ilv ? (b ^ k) : (b + k);
    endfunction

    function automatic logic [3:0] lanes_of();
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = !all_wr_n || (!lane_wr_n && !lane_en_n[i]);
        return m;
    endfunction

    task automatic model_step();
        logic blk, cpu, ctl, sel, acc, wr;
        logic [AW-1:0] a;
        logic [3:0] mk;
        if (sleep_req) begin
            if (m_slp < 2) m_slp++;
            m_wake = 0; m_rdv = 0; m_outv = 0;
            return;
        end
        blk = 0;
        if (m_slp != 0) begin blk = 1; m_slp = 0; m_wake = 1; end
        else if (m_wake != 0) begin blk = 1; m_wake--; end
        cpu = !blk && !cpu_stb_n && !sel1_n;
        ctl = !blk && !ctl_stb_n && !cpu;
        sel = !sel1_n && sel2 && !sel3_n;
        mk  = lanes_of();
        acc = 0; wr = 0; a = '0;
        if (cpu || ctl) begin
            if (sel) begin
                m_act = 1; m_base = addr_in; m_off = 0; a = addr_in; acc = 1;
                wr = ctl && (mk != 0);
            end else m_act = 0;
        end else if (m_act) begin
            if (!adv_n) m_off = m_off + 2'd1;
            a = {m_base[7:2], seq_lo(m_base[1:0], m_off, interleave)};
            acc = 1; wr = (mk != 0);
        end
        m_outv = wr ? 1'b0 : m_rdv;
        m_outd = m_rdd;
        m_rdv  = acc && !wr;
        if (acc && !wr) m_rdd = m_mem[a];
        if (wr) for (int i = 0; i < 4; i++) if (mk[i]) m_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
    endtask

    task automatic check(string tag);
        logic eoe;
        eoe = m_outv && !oe_n && (m_slp != 2);
        checks++;
        if (rdata_oe !== eoe) begin
            fails++;
            $display("FAIL %s rdata_oe actual %b expected %b at %0t", tag, rdata_oe, eoe, $time);
        end else if (eoe && rdata !== m_outd) begin
            fails++;
            $display("FAIL %s rdata actual %h expected %h at %0t", tag, rdata, m_outd, $time);
        end
    endtask

    task automatic check_val(string tag, logic [W-1:0] e);
        checks++;
        if (rdata_oe !== 1'b1 || rdata !== e) begin
            fails++;
            $display("FAIL %s oe %b rdata actual %h expected %h", tag, rdata_oe, rdata, e);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic quiet();
        cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1; sel1_n = 0; sel2 = 1; sel3_n = 0;
        all_wr_n = 1; lane_wr_n = 1; lane_en_n = 4'hF; oe_n = 0; sleep_req = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        quiet(); interleave = 0; addr_in = '0; wdata = '0; rst_n = 0;
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        m_act = 0; m_rdv = 0; m_outv = 0; m_base = '0; m_off = 0;
        m_rdd = '0; m_outd = '0; m_slp = 0; m_wake = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1");
        // R1: a fresh word reads zero
        cpu_stb_n = 0; addr_in = 8'h77; step("R1");
        quiet(); step("R1");
        check_val("R1", '0);

        // R3: controller-strobe writes of all lanes at 0x40..0x43
        for (int j = 0; j < 4; j++) begin
            quiet(); ctl_stb_n = 0; all_wr_n = 0; addr_in = 8'h40 + 8'(j);
            wdata = 36'h9_0000_0000 + 36'(j); step("R3");
        end
        quiet(); step("R3");

        // R5: linear burst from base 1
        interleave = 0; cpu_stb_n = 0; addr_in = 8'h41; step("R5");
        for (int i = 0; i < 4; i++) begin
            quiet(); adv_n = 0; step("R5");
            check_val("R5", 36'h9_0000_0000 + 36'(seq_lo(2'd1, 2'(i), 1'b0)));
        end
        quiet(); step("R5");

        // R6: interleaved burst from base 2
        interleave = 1; cpu_stb_n = 0; addr_in = 8'h42; step("R6");
        for (int i = 0; i < 4; i++) begin
            quiet(); adv_n = 0; step("R6");
            check_val("R6", 36'h9_0000_0000 + 36'(seq_lo(2'd2, 2'(i), 1'b1)));
        end
        quiet(); step("R6");

        // R7: suspend repeats the current word, wrap returns to base
        interleave = 0; cpu_stb_n = 0; addr_in = 8'h40; step("R7");
        quiet(); adv_n = 1; step("R7");
        quiet(); adv_n = 0; step("R7");
        check_val("R7", 36'h9_0000_0000);
        for (int i = 0; i < 4; i++) begin quiet(); adv_n = 0; step("R7"); end
        quiet(); step("R7");

        // R2: processor start ignores write inputs and controller strobe
        quiet(); cpu_stb_n = 0; ctl_stb_n = 0; all_wr_n = 0; addr_in = 8'h43;
        wdata = 36'hF_FFFF_FFFF; step("R2");
        quiet(); step("R2");
        check_val("R2", 36'h9_0000_0003);
        // R2: processor strobe blocked by sel1_n high
        quiet(); cpu_stb_n = 0; sel1_n = 1; addr_in = 8'h42; step("R2");
        quiet(); step("R2"); step("R2");

        // R4: lane writes on word 0x50
        quiet(); ctl_stb_n = 0; lane_wr_n = 0; lane_en_n = 4'b1011; addr_in = 8'h50;
        wdata = 36'h1_2345_6789; step("R4");
        quiet(); ctl_stb_n = 0; lane_wr_n = 0; lane_en_n = 4'b1110; addr_in = 8'h50;
        wdata = 36'hA_BCDE_F01F; step("R4");
        quiet(); ctl_stb_n = 0; lane_wr_n = 1; lane_en_n = 4'b0000; addr_in = 8'h50;
        step("R4");
        quiet(); step("R4");
        check_val("R4", {9'h0, 9'h0D1 & 9'h1FF, 9'h0, 9'h01F} & 36'h0_0FF8_01FF |
                        (36'h1_2345_6789 & (36'h1FF << 18)) | (36'hA_BCDE_F01F & 36'h1FF));

        // R9: write continuation after read start, and oe_n high
        quiet(); cpu_stb_n = 0; addr_in = 8'h41; step("R9");
        quiet(); all_wr_n = 0; wdata = 36'h5_5555_5555; step("R9");
        quiet(); oe_n = 1; adv_n = 0; step("R9");
        quiet(); oe_n = 1; step("R9");

        // R10: deselect during a burst
        quiet(); cpu_stb_n = 0; addr_in = 8'h40; step("R10");
        quiet(); ctl_stb_n = 0; sel2 = 0; step("R10");
        for (int i = 0; i < 3; i++) begin quiet(); adv_n = 0; all_wr_n = 0; step("R10"); end

        // R11: sleep in mid-burst, writes dropped, burst resumes
        quiet(); cpu_stb_n = 0; addr_in = 8'h40; step("R11");
        quiet(); adv_n = 0; step("R11");
        for (int i = 0; i < 4; i++) begin
            quiet(); sleep_req = 1; ctl_stb_n = 0; all_wr_n = 0; addr_in = 8'h60;
            wdata = 36'h7_7777_7777; step("R11");
        end
        // R12: strobes refused on two wake edges, honoured on the third
        quiet(); cpu_stb_n = 0; addr_in = 8'h60; step("R12");
        quiet(); cpu_stb_n = 0; addr_in = 8'h60; step("R12");
        quiet(); adv_n = 0; step("R12");
        quiet(); cpu_stb_n = 0; addr_in = 8'h60; step("R12");
        quiet(); step("R12");
        check_val("R12", '0);

        // R8: random traffic
        for (int c = 0; c < 3000; c++) begin
            quiet();
            if (c % 500 == 0) interleave = $urandom % 2;
            cpu_stb_n = ($urandom % 100) >= 12;
            ctl_stb_n = ($urandom % 100) >= 12;
            adv_n     = $urandom % 2;
            sel1_n    = ($urandom % 10) == 0;
            sel2      = ($urandom % 10) != 0;
            sel3_n    = ($urandom % 12) == 0;
            all_wr_n  = ($urandom % 6) != 0;
            lane_wr_n = $urandom % 2;
            lane_en_n = 4'($urandom);
            oe_n      = ($urandom % 8) == 0;
            sleep_req = ($urandom % 60) == 0;
            addr_in   = 8'h40 + 8'($urandom % 16);
            wdata     = {4'($urandom), 32'($urandom)};
            step("R8");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule